// File: doc/BRIEF.md
# One-Bit Systolic Correlator

The block correlates a stream of one-bit samples against a fixed one-bit kernel. Each sample marks a point as inside (1) or outside (0) a shape. A chain of processing elements holds the kernel, one bit per element. Each accepted sample is offered to every element at once. Each element forms the AND of its kernel bit and the sample, adds that to the partial sum handed over by its left neighbour, and registers the result. The partial sums travel down the chain. Every accepted sample therefore finishes one correlation window at the end of the chain.

Before streaming starts, the kernel is shifted in one bit per cycle through a load port. During streaming the block takes one sample per clock and returns one sum per clock, with no stalls. Gaps in the input valid freeze the chain. The window is then made only of accepted samples.

Top module: `bitcorr_array`

## Requirements
- R1: For each accepted sample n, with n at least TAPS-1, the reported sum is the sum over j=0..TAPS-1 of kern[j] AND x[n-TAPS+1+j]. Here kern[0] pairs with the oldest sample of the window and kern[TAPS-1] with the newest.
- R2: One sample is accepted in every cycle with in_valid_i=1 and ld_en_i=0. Once the window is full, every accepted sample gives out_valid_o=1 with its sum in the next cycle, including for back-to-back samples.
- R3: out_sum_o is $clog2(TAPS)+1 bits wide. An all-ones kernel against all-ones samples reports exactly TAPS.
- R4: In each cycle with ld_en_i=1, ld_bit_i enters the kernel and the older bits move one place toward kern[0]. After TAPS load cycles, the first bit loaded is kern[0] and the last is kern[TAPS-1].
- R5: In a cycle with ld_en_i=1, out_valid_o is 0 in the next cycle and in_valid_i is ignored. After a load, TAPS new accepted samples are needed before a result is reported.
- R6: After reset or a load, out_valid_o stays 0 for the first TAPS-1 accepted samples. It rises for the TAPS-th.
- R7: A cycle with no accepted sample gives out_valid_o=0 in the next cycle and leaves out_sum_o unchanged.
- R8: rst_ni low clears out_valid_o, the partial sums and the fill state. The loaded kernel is kept, so streaming may resume without a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_en_i | input | 1 | Kernel load enable |
| ld_bit_i | input | 1 | Kernel bit shifted in while loading |
| in_valid_i | input | 1 | Sample valid |
| in_bit_i | input | 1 | Sample bit |
| out_valid_o | output | 1 | Result valid |
| out_sum_o | output | $clog2(TAPS)+1 | Correlation sum |

## Verification
A kernel load and a valid sample can arrive in the same cycle. The load must win, and the sample must leave no trace in later windows. The bench raises in_valid_i throughout whole kernel loads and at random points in a mixed stream. It then expects the fill to restart and every later sum to be built only from samples taken after the load, as computed by its own window model. Mid-stream resets without a reload are also mixed in, to judge that the kernel survives reset.

// File: rtl/corr_pkg.sv
package corr_pkg;
  function automatic int sum_width(input int taps);
    return $clog2(taps) + 1;
  endfunction
endpackage

// File: rtl/corr_kernel_reg.sv
module corr_kernel_reg #(
  parameter int TAPS = 8
) (
  input  logic            clk_i,
  input  logic            ld_en_i,
  input  logic            ld_bit_i,
  output logic [TAPS-1:0] kern_o
);
  logic [TAPS-1:0] kern_q;

  // kept through reset on purpose
  always_ff @(posedge clk_i) begin
    if (ld_en_i) kern_q <= {ld_bit_i, kern_q[TAPS-1:1]};
  end

  assign kern_o = kern_q;
endmodule

// File: rtl/corr_pe.sv
module corr_pe #(
  parameter int SUM_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             kern_bit_i,
  input  logic             x_i,
  input  logic [SUM_W-1:0] sum_i,
  output logic [SUM_W-1:0] sum_o
);
  logic [SUM_W-1:0] sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sum_q <= '0;
    else if (en_i) sum_q <= sum_i + SUM_W'(kern_bit_i & x_i);
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/corr_fill_ctrl.sv
module corr_fill_ctrl #(
  parameter int TAPS = 8,
  localparam int CNT_W = $clog2(TAPS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_en_i,
  input  logic in_valid_i,
  output logic acc_o,
  output logic out_valid_o
);
  logic [CNT_W-1:0] fill_q;
  logic             vld_q;
  logic             acc;
  logic             full_next;

  assign acc       = in_valid_i & ~ld_en_i;
  assign full_next = (fill_q >= CNT_W'(TAPS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= acc & full_next;
      if (ld_en_i)                            fill_q <= '0;
      else if (acc && fill_q < CNT_W'(TAPS))  fill_q <= fill_q + 1'b1;
    end
  end

  assign acc_o       = acc;
  assign out_valid_o = vld_q;
endmodule

// File: rtl/bitcorr_array.sv
module bitcorr_array #(
  parameter int TAPS = 8,
  localparam int SUM_W = corr_pkg::sum_width(TAPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_en_i,
  input  logic             ld_bit_i,
  input  logic             in_valid_i,
  input  logic             in_bit_i,
  output logic             out_valid_o,
  output logic [SUM_W-1:0] out_sum_o
);
  logic [TAPS-1:0]  kern;
  logic             acc;
  logic [SUM_W-1:0] chain [TAPS+1];

  corr_kernel_reg #(.TAPS(TAPS)) u_kern (
    .clk_i    (clk_i),
    .ld_en_i  (ld_en_i),
    .ld_bit_i (ld_bit_i),
    .kern_o   (kern)
  );

  corr_fill_ctrl #(.TAPS(TAPS)) u_fill (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ld_en_i     (ld_en_i),
    .in_valid_i  (in_valid_i),
    .acc_o       (acc),
    .out_valid_o (out_valid_o)
  );

  assign chain[0] = '0;

  for (genvar j = 0; j < TAPS; j++) begin : g_pe
    corr_pe #(.SUM_W(SUM_W)) u_pe (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (acc),
      .kern_bit_i (kern[j]),
      .x_i        (in_bit_i),
      .sum_i      (chain[j]),
      .sum_o      (chain[j+1])
    );
  end

  assign out_sum_o = chain[TAPS];
endmodule

// File: rtl/bitcorr_array_chk.sv
module bitcorr_array_chk #(
  parameter int TAPS = 8,
  localparam int SUM_W = corr_pkg::sum_width(TAPS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ld_en_i,
  input logic             in_valid_i,
  input logic             out_valid_o,
  input logic [SUM_W-1:0] out_sum_o
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_sum_o <= SUM_W'(TAPS))); // R3

  AST_LOAD_MUTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ld_en_i) |-> !out_valid_o); // R5

  AST_VALID_FROM_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i && !ld_en_i)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(in_valid_i && !ld_en_i) |-> ($stable(out_sum_o) && !out_valid_o)); // R7
endmodule

bind bitcorr_array bitcorr_array_chk #(.TAPS(TAPS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ld_en_i     (ld_en_i),
  .in_valid_i  (in_valid_i),
  .out_valid_o (out_valid_o),
  .out_sum_o   (out_sum_o)
);

// File: tb/bitcorr_array_bench.sv
module bitcorr_array_bench;
  localparam int TAPS  = 8;
  localparam int SUM_W = $clog2(TAPS) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0, ld_bit = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
  logic             out_valid;
  logic [SUM_W-1:0] out_sum;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  bit kb [TAPS];
  bit win [TAPS];
  int fill = 0;
  bit ev = 1'b0;
  int esum = 0;
  logic [SUM_W-1:0] prev_sum = '0;

  always #10 clk = ~clk;

  bitcorr_array #(.TAPS(TAPS)) u_bitcorr_array (
    .clk_i(clk), .rst_ni(rst_n), .ld_en_i(ld_en), .ld_bit_i(ld_bit),
    .in_valid_i(in_valid), .in_bit_i(in_bit),
    .out_valid_o(out_valid), .out_sum_o(out_sum)
  );

  function automatic int window_sum();
    int s = 0;
    for (int j = 0; j < TAPS; j++) s += int'(kb[j] & win[j]);
    return s;
  endfunction

  task automatic step(input bit ld, input bit lb, input bit v, input bit b, input string tg);
    bit acc;
    @(negedge clk);
    ld_en = ld; ld_bit = lb; in_valid = v; in_bit = b;
    @(posedge clk);
    acc = v && !ld;
    if (ld) begin
      for (int j = 0; j < TAPS-1; j++) kb[j] = kb[j+1];
      kb[TAPS-1] = lb;
      fill = 0; ev = 1'b0;
    end else if (acc) begin
      for (int j = 0; j < TAPS-1; j++) win[j] = win[j+1];
      win[TAPS-1] = b;
      ev = (fill >= TAPS-1);
      if (fill < TAPS) fill++;
      esum = window_sum();
    end else ev = 1'b0;
    #1;
    checks++;
    if (out_valid !== ev) begin
      fails++;
      $display("FAIL %s valid: got %b exp %b", tg, out_valid, ev);
    end
    if (ev) begin
      checks++;
      if (out_sum !== SUM_W'(esum)) begin
        fails++;
        $display("FAIL %s R1 sum: got %0d exp %0d", tg, out_sum, esum);
      end
    end
    if (!acc) begin
      checks++;
      if (out_sum !== prev_sum) begin
        fails++;
        $display("FAIL R7 hold: got %0d exp %0d", out_sum, prev_sum);
      end
    end
    prev_sum = out_sum;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ld_en = 0; in_valid = 0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R8 reset valid: got %b exp 0", out_valid);
    end
    rst_n = 1'b1;
    fill = 0; ev = 1'b0; prev_sum = '0;
  endtask

  task automatic load_kernel(input logic [TAPS-1:0] k, input bit v_during, input string tg);
    for (int j = 0; j < TAPS; j++) step(1'b1, k[j], v_during, 1'b1, tg);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(posedge clk);
    do_reset();
    // R4: first loaded bit -> oldest sample
    load_kernel(8'b0000_0001, 1'b0, "R4");
    step(0, 0, 1, 1, "R6");
    for (int j = 0; j < TAPS-1; j++) step(0, 0, 1, 0, "R6");
    step(0, 0, 1, 0, "R4");
    // R3: full overlap
    load_kernel('1, 1'b0, "R3");
    for (int j = 0; j < TAPS+3; j++) step(0, 0, 1, 1, "R3");
    // R2: mixed kernel, back-to-back then random gaps
    load_kernel(8'b1100_1101, 1'b0, "R2");
    for (int j = 0; j < 40; j++) step(0, 0, 1, 1'($urandom), "R2");
    for (int j = 0; j < 300; j++) step(0, 0, ($urandom % 4) != 0, 1'($urandom), "R7");
    // R5: valid held high during a load
    load_kernel(8'b1011_0010, 1'b1, "R5");
    for (int j = 0; j < TAPS+10; j++) step(0, 0, 1, 1'($urandom), "R5");
    // R5: random collisions inside a stream
    for (int j = 0; j < 400; j++)
      step(($urandom % 16) == 0, 1'($urandom), ($urandom % 5) != 0, 1'($urandom), "R5");
    // R8: reset mid-stream, kernel kept
    do_reset();
    for (int j = 0; j < 60; j++) step(0, 0, ($urandom % 3) != 0, 1'($urandom), "R8");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: got hang exp finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule